// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block takes configuration read and write requests from a host and turns each one into one or two 32-bit accesses on a simple downstream configuration port. A request names a bus number, a device and function, a register byte offset, an access size of one, two or four bytes, and, for writes, the data. The block first checks alignment and whether the target can exist. It then builds the configuration address and sends it out as two parts. The upper part goes to a mapping register. The low 16 bits become the offset into a configuration window.

Bus 0 targets are addressed with a one-hot select line, placed at bit position device+10. Any other bus gets the routed encoding, which carries the bus, device and function fields. Byte and halfword reads return the selected lane of the 32-bit word. Byte and halfword writes are done as read, merge, write. Before every access the block clears the downstream abort flags. After every access it samples them, and any abort ends the request with an error status. A write also waits until the downstream busy nibble reads zero before the flags are sampled. Only one request is in flight at a time, and each one ends with a single-cycle done pulse that carries a status code.

Top module: `cfg_access_seq`

## Requirements
- R1: The size code is 0 for byte, 1 for halfword, 2 for word and 3 reserved. A request is answered with status 1 (bad register) and makes no downstream access if it is a halfword at an odd offset, a word whose offset has either low bit set, or uses size code 3.
- R2: An aligned request on bus 0 is answered with status 2 (no device) and makes no downstream access if the device number is above MAX_DEV0 (default 21) or equals EXCL_SLOT (default 17). The alignment check of R1 takes precedence.
- R3: On bus 0, the 32-bit pattern is 1<<(device+10), ORed with function<<8 and with the offset whose low two bits are cleared. The mapping value is pattern[31:16] with bit 16 clear, and the window offset is pattern[15:0].
- R4: On any other bus, the mapping value has bit 16 set and the bus number in bits 7:0. The window offset holds the device at bits 15:11, the function at bits 10:8 and the dword-aligned register offset at bits 7:0. The address and the direction stay stable while a request waits for its acknowledge.
- R5: Before each downstream access the block pulses the abort-clear output and writes the mapping register. After the access it samples the master and target abort flags. If either is set, it pulses the abort-clear output again and ends the request with status 3 (abort).
- R6: After a write is acknowledged, the abort flags are not sampled and done is not signalled until the busy nibble reads zero.
- R7: A byte or halfword write reads the containing word first. It then writes back the word with only the lane at bit position (offset mod 4)×8 replaced by the low 8 or 16 bits of the write data.
- R8: A word write makes exactly one downstream access, a write of the request data, with no read.
- R9: A successful read returns the word shifted right by (offset mod 4)×8 and masked to 8, 16 or 32 bits. Every other outcome returns zero data.
- R10: If the read phase of a read-modify-write aborts, no write follows, and the request ends with status 3 after a single access.
- R11: req_ready is high only while idle. It drops after a request is accepted. done_pulse lasts exactly one cycle per request and carries the status (0 success).
- R12: After reset, req_ready is high and dn_req and done_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word, 3 reserved) |
| req_wdata | input | 32 | Write data, right-aligned |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_status | output | 2 | 0 ok, 1 bad register, 2 no device, 3 abort |
| done_rdata | output | 32 | Read data, right-aligned |
| dn_map_wr | output | 1 | Mapping-register write strobe |
| dn_map_data | output | 17 | Mapping value, bit 16 is the routed-type flag |
| dn_req | output | 1 | Window access request, held until acknowledge |
| dn_write | output | 1 | Direction of the window access |
| dn_addr | output | 16 | Window offset |
| dn_wdata | output | 32 | Window write data |
| dn_ack | input | 1 | Window access acknowledge |
| dn_rdata | input | 32 | Window read data, valid with acknowledge |
| dn_busy | input | BUSY_W | Downstream busy nibble |
| dn_mabort | input | 1 | Sticky master-abort flag |
| dn_tabort | input | 1 | Sticky target-abort flag |
| dn_abort_clr | output | 1 | Clears both abort flags |

## Verification
Random requests mix bus 0 and routed buses, every size code, and aligned and unaligned offsets. This tells apart the two address encodings and the three early outcomes: bad register, no device, and a normal access. Byte and halfword writes at each lane are compared with a restated merge, which separates the replaced lane from the bytes that must survive. Aborts are injected on the first or second access, and write busy times range from zero to five cycles. Together these separate an abort in the read phase of a read-modify-write from one in its write phase, and show that done waits for busy to clear. Directed cases cover the highest valid bus 0 slot, the excluded slot, the first rejected slot and the extreme field values of the routed encoding.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 8;
  localparam int WORD_W = 32;
  localparam int WIN_W  = 16;
  localparam int MAP_W  = WORD_W - WIN_W + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    RS_OK     = 2'd0,
    RS_BADREG = 2'd1,
    RS_NODEV  = 2'd2,
    RS_ABORT  = 2'd3
  } resp_e;

  function automatic logic misaligned(size_e sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return lo[0];
      SZ_WORD: return |lo;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [4:0] lane_shift(logic [1:0] lo);
    return {lo, 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_extract(logic [WORD_W-1:0] word,
                                                     size_e sz, logic [1:0] lo);
    return (word >> lane_shift(lo)) & lane_mask(sz);
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(logic [WORD_W-1:0] word,
                                                   logic [WORD_W-1:0] wdata,
                                                   size_e sz, logic [1:0] lo);
    logic [WORD_W-1:0] m;
    m = lane_mask(sz) << lane_shift(lo);
    return (word & ~m) | ((wdata & lane_mask(sz)) << lane_shift(lo));
  endfunction

  function automatic logic [WORD_W-1:0] local_pattern(logic [DEV_W-1:0] dev,
                                                      logic [FUNC_W-1:0] fn,
                                                      logic [REG_W-1:0] rg);
    logic [5:0] pos;
    pos = {1'b0, dev} + 6'd10;
    return (32'd1 << pos) | {21'b0, fn, rg[7:2], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] routed_pattern(logic [BUS_W-1:0] bus,
                                                       logic [DEV_W-1:0] dev,
                                                       logic [FUNC_W-1:0] fn,
                                                       logic [REG_W-1:0] rg);
    return {8'b0, bus, dev, fn, rg[7:2], 2'b00};
  endfunction
endpackage

// File: rtl/cfg_addr_encoder.sv
module cfg_addr_encoder
  import cfg_seq_pkg::*;
#(
  parameter int MAX_DEV0  = 21,
  parameter int EXCL_SLOT = 17,
  parameter bit EXCL_EN   = 1'b1
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] fn,
  input  logic [REG_W-1:0]  rg,
  output logic [MAP_W-1:0]  map_val,
  output logic [WIN_W-1:0]  win_off,
  output logic              dev_reject
);
  logic              routed;
  logic [WORD_W-1:0] pattern;
  logic              too_high;
  logic              slot_hit;

  assign routed   = |bus;
  assign pattern  = routed ? routed_pattern(bus, dev, fn, rg) : local_pattern(dev, fn, rg);
  assign map_val  = {routed, pattern[WORD_W-1:WIN_W]};
  assign win_off  = pattern[WIN_W-1:0];
  assign too_high = !routed && (int'({27'b0, dev}) > MAX_DEV0);

  generate
    if (EXCL_EN) begin : g_excl
      assign slot_hit = !routed && (int'({27'b0, dev}) == EXCL_SLOT);
    end else begin : g_noexcl
      assign slot_hit = 1'b0;
    end
  endgenerate

  assign dev_reject = too_high | slot_hit;
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_seq_pkg::*;
(
  input  logic [WORD_W-1:0] raw_word,
  input  logic [WORD_W-1:0] wdata,
  input  size_e             sz,
  input  logic [1:0]        lo,
  output logic [WORD_W-1:0] rd_lane,
  output logic [WORD_W-1:0] wr_word
);
  assign rd_lane = lane_extract(raw_word, sz, lo);
  assign wr_word = lane_merge(raw_word, wdata, sz, lo);
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int BUSY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              take,
  input  logic              lat_write,
  input  size_e             lat_size,
  input  logic [1:0]        lat_lo,
  input  logic              dev_reject,
  output logic              dn_req,
  output logic              dn_write,
  input  logic              dn_ack,
  input  logic [BUSY_W-1:0] dn_busy,
  input  logic              dn_mabort,
  input  logic              dn_tabort,
  output logic              dn_abort_clr,
  output logic              dn_map_wr,
  output logic              cap_rd,
  output logic              finish,
  output logic              finish_rd_ok,
  output logic              acc_fire,
  output logic              wr_fire,
  output logic              done_pulse,
  output resp_e             done_status
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SETUP, S_ACC, S_BUSYW, S_SAMPLE
  } st_e;

  st_e   st, nxt;
  logic  phase_wr, nxt_ph;
  resp_e fin_st;
  logic  bad_reg;

  assign bad_reg = misaligned(lat_size, lat_lo);

  always_comb begin
    nxt          = st;
    nxt_ph       = phase_wr;
    take         = 1'b0;
    dn_req       = 1'b0;
    dn_abort_clr = 1'b0;
    dn_map_wr    = 1'b0;
    cap_rd       = 1'b0;
    finish       = 1'b0;
    fin_st       = RS_OK;
    case (st)
      S_IDLE: begin
        if (req_valid) begin
          take = 1'b1;
          nxt  = S_CHECK;
        end
      end
      S_CHECK: begin
        if (bad_reg) begin
          finish = 1'b1;
          fin_st = RS_BADREG;
          nxt    = S_IDLE;
        end else if (dev_reject) begin
          finish = 1'b1;
          fin_st = RS_NODEV;
          nxt    = S_IDLE;
        end else begin
          nxt    = S_SETUP;
          nxt_ph = lat_write && (lat_size == SZ_WORD);
        end
      end
      S_SETUP: begin
        dn_abort_clr = 1'b1;
        dn_map_wr    = 1'b1;
        nxt          = S_ACC;
      end
      S_ACC: begin
        dn_req = 1'b1;
        if (dn_ack) begin
          if (phase_wr) begin
            nxt = S_BUSYW;
          end else begin
            cap_rd = 1'b1;
            nxt    = S_SAMPLE;
          end
        end
      end
      S_BUSYW: begin
        if (dn_busy == '0) nxt = S_SAMPLE;
      end
      S_SAMPLE: begin
        if (dn_mabort || dn_tabort) begin
          dn_abort_clr = 1'b1;
          finish       = 1'b1;
          fin_st       = RS_ABORT;
          nxt          = S_IDLE;
        end else if (lat_write && !phase_wr) begin
          nxt_ph = 1'b1;
          nxt    = S_SETUP;
        end else begin
          finish = 1'b1;
          fin_st = RS_OK;
          nxt    = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign req_ready    = (st == S_IDLE);
  assign dn_write     = phase_wr;
  assign acc_fire     = dn_req && dn_ack;
  assign wr_fire      = acc_fire && phase_wr;
  assign finish_rd_ok = finish && (fin_st == RS_OK) && !lat_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      phase_wr    <= 1'b0;
      done_pulse  <= 1'b0;
      done_status <= RS_OK;
    end else begin
      st         <= nxt;
      phase_wr   <= nxt_ph;
      done_pulse <= finish;
      if (finish) done_status <= fin_st;
    end
  end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_seq_pkg::*;
#(
  parameter int MAX_DEV0  = 21,
  parameter int EXCL_SLOT = 17,
  parameter bit EXCL_EN   = 1'b1,
  parameter int BUSY_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_func,
  input  logic [7:0]        req_reg,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              done_pulse,
  output logic [1:0]        done_status,
  output logic [31:0]       done_rdata,
  output logic              dn_map_wr,
  output logic [16:0]       dn_map_data,
  output logic              dn_req,
  output logic              dn_write,
  output logic [15:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic [31:0]       dn_rdata,
  input  logic [BUSY_W-1:0] dn_busy,
  input  logic              dn_mabort,
  input  logic              dn_tabort,
  output logic              dn_abort_clr
);
  logic              l_write;
  logic [BUS_W-1:0]  l_bus;
  logic [DEV_W-1:0]  l_dev;
  logic [FUNC_W-1:0] l_func;
  logic [REG_W-1:0]  l_reg;
  size_e             l_size;
  logic [WORD_W-1:0] l_wdata;
  logic [WORD_W-1:0] raw_word;

  logic              take, cap_rd, finish, finish_rd_ok;
  logic              acc_fire, wr_fire, dev_reject;
  logic [WORD_W-1:0] rd_lane, wr_word;
  resp_e             st_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_write  <= 1'b0;
      l_bus    <= '0;
      l_dev    <= '0;
      l_func   <= '0;
      l_reg    <= '0;
      l_size   <= SZ_BYTE;
      l_wdata  <= '0;
      raw_word <= '0;
      done_rdata <= '0;
    end else begin
      if (take) begin
        l_write <= req_write;
        l_bus   <= req_bus;
        l_dev   <= req_dev;
        l_func  <= req_func;
        l_reg   <= req_reg;
        l_size  <= size_e'(req_size);
        l_wdata <= req_wdata;
      end
      if (cap_rd) raw_word <= dn_rdata;
      if (finish) done_rdata <= finish_rd_ok ? rd_lane : '0;
    end
  end

  cfg_addr_encoder #(
    .MAX_DEV0 (MAX_DEV0),
    .EXCL_SLOT(EXCL_SLOT),
    .EXCL_EN  (EXCL_EN)
  ) u_enc (
    .bus       (l_bus),
    .dev       (l_dev),
    .fn        (l_func),
    .rg        (l_reg),
    .map_val   (dn_map_data),
    .win_off   (dn_addr),
    .dev_reject(dev_reject)
  );

  cfg_lane_unit u_lane (
    .raw_word(raw_word),
    .wdata   (l_wdata),
    .sz      (l_size),
    .lo      (l_reg[1:0]),
    .rd_lane (rd_lane),
    .wr_word (wr_word)
  );

  cfg_seq_ctrl #(.BUSY_W(BUSY_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .take        (take),
    .lat_write   (l_write),
    .lat_size    (l_size),
    .lat_lo      (l_reg[1:0]),
    .dev_reject  (dev_reject),
    .dn_req      (dn_req),
    .dn_write    (dn_write),
    .dn_ack      (dn_ack),
    .dn_busy     (dn_busy),
    .dn_mabort   (dn_mabort),
    .dn_tabort   (dn_tabort),
    .dn_abort_clr(dn_abort_clr),
    .dn_map_wr   (dn_map_wr),
    .cap_rd      (cap_rd),
    .finish      (finish),
    .finish_rd_ok(finish_rd_ok),
    .acc_fire    (acc_fire),
    .wr_fire     (wr_fire),
    .done_pulse  (done_pulse),
    .done_status (st_code)
  );

  assign done_status = st_code;
  assign dn_wdata    = wr_word;
endmodule

// File: rtl/cfg_access_seq_chk.sv
module cfg_access_seq_chk #(
  parameter int BUSY_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              dn_req,
  input logic              dn_ack,
  input logic              dn_write,
  input logic [15:0]       dn_addr,
  input logic [BUSY_W-1:0] dn_busy,
  input logic              dn_abort_clr,
  input logic              dn_map_wr,
  input logic              done_pulse,
  input logic [1:0]        done_status,
  input logic              acc_fire,
  input logic              wr_fire
);
  logic acc_seen, clr_armed, map_armed, wr_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_seen  <= 1'b0;
      clr_armed <= 1'b0;
      map_armed <= 1'b0;
      wr_wait   <= 1'b0;
    end else begin
      if (req_valid && req_ready) acc_seen <= 1'b0;
      else if (dn_req)            acc_seen <= 1'b1;
      if (acc_fire)          clr_armed <= 1'b0;
      else if (dn_abort_clr) clr_armed <= 1'b1;
      if (acc_fire)       map_armed <= 1'b0;
      else if (dn_map_wr) map_armed <= 1'b1;
      if (done_pulse)   wr_wait <= 1'b0;
      else if (wr_fire) wr_wait <= 1'b1;
    end
  end

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R1
  early_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse && (done_status == 2'd1 || done_status == 2'd2) |-> !acc_seen);

  // R5
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> clr_armed && map_armed);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wait && (dn_busy != '0) |=> !done_pulse);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_write));
endmodule

bind cfg_access_seq cfg_access_seq_chk #(.BUSY_W(BUSY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .dn_req      (dn_req),
  .dn_ack      (dn_ack),
  .dn_write    (dn_write),
  .dn_addr     (dn_addr),
  .dn_busy     (dn_busy),
  .dn_abort_clr(dn_abort_clr),
  .dn_map_wr   (dn_map_wr),
  .done_pulse  (done_pulse),
  .done_status (done_status),
  .acc_fire    (acc_fire),
  .wr_fire     (wr_fire)
);

// File: tb/cfg_access_seq_bench.sv
`timescale 1ns/1ps
module cfg_access_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_reg = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        done_pulse;
  logic [1:0]  done_status;
  logic [31:0] done_rdata;
  logic        dn_map_wr;
  logic [16:0] dn_map_data;
  logic        dn_req, dn_write;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_ack;
  logic [31:0] dn_rdata;
  logic [3:0]  dn_busy;
  logic        dn_mabort, dn_tabort;
  logic        dn_abort_clr;

  always #10 clk = ~clk;

  cfg_access_seq u_cfg_access_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
    .req_size(req_size), .req_wdata(req_wdata),
    .done_pulse(done_pulse), .done_status(done_status), .done_rdata(done_rdata),
    .dn_map_wr(dn_map_wr), .dn_map_data(dn_map_data),
    .dn_req(dn_req), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_busy(dn_busy),
    .dn_mabort(dn_mabort), .dn_tabort(dn_tabort), .dn_abort_clr(dn_abort_clr)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural configuration space
  logic [31:0] mem [logic [32:0]];

  function automatic logic [31:0] peek(logic [32:0] key);
    if (mem.exists(key)) return mem[key];
    return {key[15:0], key[31:16]} ^ {15'b0, key[32], 16'h0} ^ 32'h1357_9BDF;
  endfunction

  // responder state
  int          inj_at = 9;
  bit          inj_tab = 1'b0;
  int          busy_len = 0;
  int          acc_idx = 0;
  int          dirty = 0;
  logic [16:0] acc_map [0:3];
  logic [15:0] acc_win [0:3];
  logic        acc_wr  [0:3];
  logic [31:0] acc_wd  [0:3];
  logic [16:0] map_reg;
  int          lat_cnt;
  int          busy_cnt;

  assign dn_busy = (busy_cnt != 0) ? 4'b0110 : 4'b0000;

  always @(posedge clk) begin
    if (!rst_n) begin
      dn_ack    <= 1'b0;
      dn_rdata  <= '0;
      map_reg   <= '0;
      dn_mabort <= 1'b0;
      dn_tabort <= 1'b0;
      lat_cnt   <= 0;
      busy_cnt  <= 0;
    end else begin
      if (dn_map_wr) map_reg <= dn_map_data;
      if (dn_abort_clr) begin
        dn_mabort <= 1'b0;
        dn_tabort <= 1'b0;
      end
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (dn_ack) begin
        dn_ack <= 1'b0;
      end else if (dn_req) begin
        if (lat_cnt != 0) begin
          lat_cnt <= lat_cnt - 1;
        end else begin
          dn_ack <= 1'b1;
          if (dn_mabort || dn_tabort) dirty++;
          if (acc_idx < 4) begin
            acc_map[acc_idx] = map_reg;
            acc_win[acc_idx] = dn_addr;
            acc_wr[acc_idx]  = dn_write;
            acc_wd[acc_idx]  = dn_wdata;
          end
          if (dn_write) begin
            mem[{map_reg, dn_addr}] = dn_wdata;
            busy_cnt <= busy_len;
          end else begin
            dn_rdata <= peek({map_reg, dn_addr});
          end
          if (acc_idx == inj_at) begin
            if (inj_tab) dn_tabort <= 1'b1;
            else         dn_mabort <= 1'b1;
          end
          acc_idx++;
          lat_cnt <= int'($urandom_range(0, 2));
        end
      end
    end
  end

  // bench restatement of the address rules
  function automatic logic [16:0] b_map(logic [7:0] bus, logic [4:0] dev,
                                        logic [2:0] fn, logic [7:0] rg);
    logic [63:0] a;
    if (bus == 8'd0) a = 64'd1 << (int'(dev) + 10);
    else             a = (64'(bus) << 16) | (64'(dev) << 11);
    a = a | (64'(fn) << 8) | 64'(rg & 8'hFC);
    return 17'(a >> 16) | ((bus != 8'd0) ? 17'h10000 : 17'h0);
  endfunction

  function automatic logic [15:0] b_win(logic [7:0] bus, logic [4:0] dev,
                                        logic [2:0] fn, logic [7:0] rg);
    logic [63:0] a;
    if (bus == 8'd0) a = 64'd1 << (int'(dev) + 10);
    else             a = (64'(bus) << 16) | (64'(dev) << 11);
    a = a | (64'(fn) << 8) | 64'(rg & 8'hFC);
    return a[15:0];
  endfunction

  function automatic logic [31:0] b_extract(logic [31:0] w, logic [1:0] sz, logic [1:0] lo);
    logic [7:0] b [0:3];
    for (int k = 0; k < 4; k++) b[k] = w[8*k +: 8];
    case (sz)
      2'd0:    return {24'h0, b[lo]};
      2'd1:    return {16'h0, b[lo + 2'd1], b[lo]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] b_merge(logic [31:0] w, logic [31:0] wd,
                                          logic [1:0] sz, logic [1:0] lo);
    logic [31:0] r;
    r = w;
    case (sz)
      2'd0:    r[8*lo +: 8]  = wd[7:0];
      2'd1:    r[8*lo +: 16] = wd[15:0];
      default: r = wd;
    endcase
    return r;
  endfunction

  task automatic run_req(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [7:0] rg, input logic [1:0] sz,
                         input logic [31:0] wd, input int inj, input bit inj_t,
                         input int busy);
    bit          bad, rej;
    int          n_exp, n_acc, wait_n;
    logic [1:0]  st_exp;
    logic [16:0] m_exp;
    logic [15:0] w_exp;
    logic [31:0] old, r_exp, wd_exp;
    bad = (sz == 2'd3) || (sz == 2'd1 && rg[0]) || (sz == 2'd2 && rg[1:0] != 2'd0);
    rej = !bad && bus == 8'd0 && (dev > 5'd21 || dev == 5'd17);
    n_exp = (bad || rej) ? 0 : ((wr && sz != 2'd2) ? 2 : 1);
    m_exp = b_map(bus, dev, fn, rg);
    w_exp = b_win(bus, dev, fn, rg);
    old   = peek({m_exp, w_exp});
    wd_exp = b_merge(old, wd, sz, rg[1:0]);
    if (bad)                st_exp = 2'd1;
    else if (rej)           st_exp = 2'd2;
    else if (inj < n_exp)   st_exp = 2'd3;
    else                    st_exp = 2'd0;
    n_acc = (st_exp == 2'd3) ? inj + 1 : n_exp;
    r_exp = (st_exp == 2'd0 && !wr) ? b_extract(old, sz, rg[1:0]) : 32'h0;

    @(negedge clk);
    inj_at = inj; inj_tab = inj_t; busy_len = busy; acc_idx = 0; dirty = 0;
    req_write = wr; req_bus = bus; req_dev = dev; req_func = fn;
    req_reg = rg; req_size = sz; req_wdata = wd; req_valid = 1'b1;
    wait_n = 0;
    while (!req_ready && wait_n < 500) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11", "ready after accept", 32'(req_ready), 32'd0);
    wait_n = 0;
    while (!done_pulse && wait_n < 500) begin @(negedge clk); wait_n++; end
    if (!done_pulse) begin
      chk(1'b0, "R11", "done timeout", 32'd0, 32'd1);
      return;
    end
    if (bad)      chk(done_status == st_exp, "R1", "status", 32'(done_status), 32'(st_exp));
    else if (rej) chk(done_status == st_exp, "R2", "status", 32'(done_status), 32'(st_exp));
    else          chk(done_status == st_exp, "R5", "status", 32'(done_status), 32'(st_exp));
    chk(done_rdata == r_exp, "R9", "read data", done_rdata, r_exp);
    if (wr && sz != 2'd2 && inj == 0)
      chk(acc_idx == n_acc, "R10", "access count", 32'(acc_idx), 32'(n_acc));
    else if (wr && sz == 2'd2 && n_exp > 0)
      chk(acc_idx == n_acc, "R8", "access count", 32'(acc_idx), 32'(n_acc));
    else
      chk(acc_idx == n_acc, "R1", "access count", 32'(acc_idx), 32'(n_acc));
    if (n_acc > 0) begin
      if (bus == 8'd0) begin
        chk(acc_map[0] == m_exp, "R3", "map value", 32'(acc_map[0]), 32'(m_exp));
        chk(acc_win[0] == w_exp, "R3", "window offset", 32'(acc_win[0]), 32'(w_exp));
      end else begin
        chk(acc_map[0] == m_exp, "R4", "map value", 32'(acc_map[0]), 32'(m_exp));
        chk(acc_win[0] == w_exp, "R4", "window offset", 32'(acc_win[0]), 32'(w_exp));
      end
      chk(acc_wr[0] == (wr && sz == 2'd2), "R8", "first access direction",
          32'(acc_wr[0]), 32'(wr && sz == 2'd2));
      if (wr && n_acc == n_exp) begin
        chk(acc_wr[n_acc-1] == 1'b1, "R7", "last access is write", 32'(acc_wr[n_acc-1]), 32'd1);
        chk(acc_wd[n_acc-1] == wd_exp, "R7", "written word", acc_wd[n_acc-1], wd_exp);
        chk(acc_map[n_acc-1] == m_exp, "R5", "map rewritten", 32'(acc_map[n_acc-1]), 32'(m_exp));
      end
      chk(dirty == 0, "R5", "flags clear at access", 32'(dirty), 32'd0);
    end
    chk(!dn_mabort && !dn_tabort, "R5", "flags clear at done",
        32'({dn_mabort, dn_tabort}), 32'd0);
    if (wr && n_acc > 0 && acc_wr[n_acc-1])
      chk(dn_busy == 4'd0, "R6", "busy at done", 32'(dn_busy), 32'd0);
    @(negedge clk);
    chk(!done_pulse, "R11", "done width", 32'(done_pulse), 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd24681357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 32'd1);
    chk(dn_req == 1'b0, "R12", "dn_req after reset", 32'(dn_req), 32'd0);
    chk(done_pulse == 1'b0, "R12", "done after reset", 32'(done_pulse), 32'd0);

    // directed corner cases
    run_req(1'b0, 8'd0, 5'd21, 3'd0, 8'h00, 2'd2, 32'h0, 9, 1'b0, 0); // R3 top slot
    run_req(1'b0, 8'd0, 5'd22, 3'd0, 8'h00, 2'd2, 32'h0, 9, 1'b0, 0); // R2 first rejected
    run_req(1'b1, 8'd0, 5'd17, 3'd1, 8'h04, 2'd2, 32'h1, 9, 1'b0, 0); // R2 excluded slot
    run_req(1'b0, 8'd0, 5'd22, 3'd0, 8'h03, 2'd1, 32'h0, 9, 1'b0, 0); // R1 before R2
    run_req(1'b0, 8'd3, 5'd2, 3'd0, 8'h06, 2'd2, 32'h0, 9, 1'b0, 0);  // R1 word at 2
    run_req(1'b1, 8'd3, 5'd2, 3'd0, 8'h04, 2'd3, 32'h0, 9, 1'b0, 0);  // R1 reserved
    run_req(1'b0, 8'd255, 5'd31, 3'd7, 8'hFF, 2'd0, 32'h0, 9, 1'b0, 0); // R4 extremes
    run_req(1'b1, 8'd9, 5'd4, 3'd2, 8'h12, 2'd1, 32'hBEEF_CAFE, 9, 1'b0, 2); // R7 half
    run_req(1'b0, 8'd9, 5'd4, 3'd2, 8'h12, 2'd1, 32'h0, 9, 1'b0, 0);  // R9 readback
    run_req(1'b1, 8'd0, 5'd3, 3'd1, 8'h21, 2'd0, 32'h0000_00A5, 0, 1'b0, 0); // R10
    run_req(1'b1, 8'd0, 5'd3, 3'd1, 8'h21, 2'd0, 32'h0000_005A, 1, 1'b1, 3); // R5 write abort
    run_req(1'b1, 8'd7, 5'd1, 3'd0, 8'h40, 2'd2, 32'h1234_5678, 0, 1'b1, 5); // R6 R8

    // constrained random
    for (int i = 0; i < 500; i++) begin
      logic [7:0] bus, rg;
      logic [4:0] dev;
      logic [1:0] sz;
      int         inj, r;
      bus = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
      dev = (bus == 8'd0) ? 5'($urandom_range(0, 23)) : 5'($urandom_range(0, 31));
      r   = int'($urandom_range(0, 9));
      sz  = (r == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      rg  = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 9) < 7) begin
        if (sz == 2'd1) rg[0] = 1'b0;
        if (sz == 2'd2) rg[1:0] = 2'b00;
      end
      r   = int'($urandom_range(0, 7));
      inj = (r == 0) ? 0 : ((r == 1) ? 1 : 9);
      run_req(1'($urandom_range(0, 1)), bus, dev, 3'($urandom_range(0, 7)), rg, sz,
              $urandom(), inj, 1'($urandom_range(0, 1)), int'($urandom_range(0, 5)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule